// File: doc/BRIEF.md
# SPI Pin Router and Bit-Rate Prescaler

This block is the pad-facing half of an SPI port. It owns the four serial pads (master-in data, master-out data, serial clock and slave select). For each pad it decides whether the pad is driven and which internal signal it carries. It also picks which pad feeds the receive path. These choices follow from the master/slave mode, a single-wire bidirectional mode, a direction bit per pad and an enable that lets a master drive its own slave select. In single-wire mode, one data pad carries both directions. The other data pad becomes a plain general-purpose pin whose output level comes from a register.

The block also holds a 3-bit rate code and produces a one-cycle tick at twice the serial clock rate. The transfer logic uses these ticks to place both the leading and the trailing clock edges. For rate code k the serial clock period is 2^(k+1) system cycles, so the tick period is 2^k cycles. The tick counter restarts whenever the rate code is written or a transfer starts. The first edge after either event therefore comes a whole tick period later.

Top module: `spi_pinctl`

## Requirements
- R1: After reset, every register reads zero. All four entries of `pad_oe` are 0. The rate code is 0, so `sck_tick` is high on every cycle.
- R2: The rate register is at address 2, with the code in bits [2:0]. Its upper bits always read 0. It accepts a write on any cycle, including one with `xfer_start` high.
- R3: With rate code k, `sck_tick` is high once every 2^k cycles, which is half the serial clock period of 2^(k+1) cycles.
- R4: A rate write or an `xfer_start` pulse clears the tick counter. Take the first cycle after the clearing edge as cycle 0. The tick is then high exactly in the cycles j where j mod 2^k equals 2^k-1.
- R5: Normal mode (control bit1 = 0): a master (control bit0 = 1) takes receive data from MISO and drives `tx_bit` on MOSI. A slave takes receive data from MOSI and drives `tx_bit` on MISO.
- R6: Single-wire mode (control bit1 = 1): a master uses MOSI as the shared data pad and treats MISO as a general-purpose pin. A slave uses MISO as the shared data pad and treats MOSI as a general-purpose pin. A general-purpose pin is driven when its direction bit is 1. Its output level comes from address 3: bit0 for MISO and bit1 for MOSI. A read of address 3 returns {MOSI level, MISO level} in bits [1:0].
- R7: In either mode, a slave drives `tx_bit` on MISO only while MISO's direction bit (address 1, bit0) is 1 and the slave-select pad is low.
- R8: A master drives MOSI only while MOSI's direction bit (address 1, bit1) is 1.
- R9: SCK is driven with `sck_drv` only in master mode with the SCK direction bit (address 1, bit2) set. Otherwise it is an input, seen on `sck_rx`.
- R10: SS is driven with `ss_drv` only in master mode with both the SS direction bit (address 1, bit3) and the SS output enable (control bit2) set. Otherwise it is an input, seen on `ss_rx`.
- R11: `rx_bit` carries the level of MISO when exactly one of master and single-wire is set, and the level of MOSI otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 direction, 2 rate, 3 general-purpose data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| xfer_start | input | 1 | Transfer start pulse; clears the prescaler |
| tx_bit | input | 1 | Serial data from the shifter |
| sck_drv | input | 1 | Serial clock level a master drives |
| ss_drv | input | 1 | Slave-select level a master drives |
| rx_bit | output | 1 | Receive data taken from the selected pad |
| sck_rx | output | 1 | Level on the SCK pad |
| ss_rx | output | 1 | Level on the SS pad |
| sck_tick | output | 1 | One-cycle tick at twice the serial clock rate |
| pad_oe | output | 4 | Output enables: [0] MISO, [1] MOSI, [2] SCK, [3] SS |
| miso_pad | inout | 1 | MISO pad |
| mosi_pad | inout | 1 | MOSI pad |
| sck_pad | inout | 1 | SCK pad |
| ss_pad | inout | 1 | SS pad |

## Verification
The output-enable assertions assume that the SS pad carries a defined level whenever the block does not drive it. They also assume that nothing outside fights a pad the block is driving. Before each register change the bench releases every pad. After the change, it drives only the pads the expected enables leave free, and it always holds SS at a known level. The prescaler assertions assume the rate code changes only through a register write. The bench changes the code only that way.

// File: rtl/spi_pinctl_pkg.sv
package spi_pinctl_pkg;

  localparam int PIN_MISO = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SS   = 3;
  localparam int NPIN     = 4;

  typedef enum logic [1:0] {
    ADR_CTL  = 2'd0,
    ADR_DIR  = 2'd1,
    ADR_RATE = 2'd2,
    ADR_GPIO = 2'd3
  } reg_adr_e;

  typedef struct packed {
    logic ss_oe;
    logic bidi;
    logic master;
  } ctl_t;

  // cycles between prescaler ticks for a rate code
  function automatic int unsigned tick_period(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // true when the receive path takes MISO
  function automatic logic rx_from_miso(input logic master, input logic bidi);
    return master ^ bidi;
  endfunction

endpackage

// File: rtl/spi_pinctl_regs.sv
module spi_pinctl_regs
  import spi_pinctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          gpio_lvl,
  output ctl_t                ctl,
  output logic [NPIN-1:0]     dir,
  output logic [RATE_W-1:0]   rate,
  output logic [1:0]          gpio_out,
  output logic                rate_wr
);

  logic ctl_we, dir_we, rate_we, gpio_we;

  assign ctl_we  = wr_en && (addr == ADR_CTL);
  assign dir_we  = wr_en && (addr == ADR_DIR);
  assign rate_we = wr_en && (addr == ADR_RATE);
  assign gpio_we = wr_en && (addr == ADR_GPIO);
  assign rate_wr = rate_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      dir      <= '0;
      rate     <= '0;
      gpio_out <= '0;
    end else begin
      if (ctl_we)  ctl      <= ctl_t'(wdata[2:0]);
      if (dir_we)  dir      <= wdata[NPIN-1:0];
      if (rate_we) rate     <= wdata[RATE_W-1:0];
      if (gpio_we) gpio_out <= wdata[1:0];
    end
  end

  always_comb begin
    unique case (addr)
      ADR_CTL:  rdata = DATA_W'(ctl);
      ADR_DIR:  rdata = DATA_W'(dir);
      ADR_RATE: rdata = DATA_W'(rate);
      default:  rdata = DATA_W'(gpio_lvl);
    endcase
  end

endmodule

// File: rtl/spi_pinctl_route.sv
module spi_pinctl_route
  import spi_pinctl_pkg::*;
(
  input  ctl_t            ctl,
  input  logic [NPIN-1:0] dir,
  input  logic            ss_lvl,
  input  logic            tx_bit,
  input  logic            sck_drv,
  input  logic            ss_drv,
  input  logic [1:0]      gpio_out,
  input  logic [NPIN-1:0] pad_lvl,
  output logic [NPIN-1:0] oe,
  output logic [NPIN-1:0] val,
  output logic            rx_bit
);

  logic slave_drive;
  logic miso_gpio, mosi_gpio;

  assign slave_drive = dir[PIN_MISO] && !ss_lvl && !ctl.master;
  assign miso_gpio   = ctl.bidi && ctl.master;
  assign mosi_gpio   = ctl.bidi && !ctl.master;

  always_comb begin
    // MISO: slave data out, or a general-purpose pin for a single-wire master
    if (miso_gpio) begin
      oe[PIN_MISO]  = dir[PIN_MISO];
      val[PIN_MISO] = gpio_out[0];
    end else begin
      oe[PIN_MISO]  = slave_drive;
      val[PIN_MISO] = tx_bit;
    end
    // MOSI: master data out, or a general-purpose pin for a single-wire slave
    if (mosi_gpio) begin
      oe[PIN_MOSI]  = dir[PIN_MOSI];
      val[PIN_MOSI] = gpio_out[1];
    end else begin
      oe[PIN_MOSI]  = dir[PIN_MOSI] && ctl.master;
      val[PIN_MOSI] = tx_bit;
    end
    oe[PIN_SCK]  = dir[PIN_SCK] && ctl.master;
    val[PIN_SCK] = sck_drv;
    oe[PIN_SS]   = dir[PIN_SS] && ctl.ss_oe && ctl.master;
    val[PIN_SS]  = ss_drv;
  end

  assign rx_bit = rx_from_miso(ctl.master, ctl.bidi) ? pad_lvl[PIN_MISO]
                                                      : pad_lvl[PIN_MOSI];

endmodule

// File: rtl/spi_pinctl_presc.sv
module spi_pinctl_presc #(
  parameter int RATE_W = 3,
  parameter int CNT_W  = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              clr,
  output logic [CNT_W-1:0]  cnt,
  output logic              tick
);

  logic [CNT_W-1:0] lim;
  logic             at_lim;

  assign lim    = CNT_W'(spi_pinctl_pkg::tick_period(32'(rate)) - 1);
  assign at_lim = (cnt == lim);
  assign tick   = at_lim && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (at_lim) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_pinctl.sv
module spi_pinctl
  import spi_pinctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_start,
  input  logic              tx_bit,
  input  logic              sck_drv,
  input  logic              ss_drv,
  output logic              rx_bit,
  output logic              sck_rx,
  output logic              ss_rx,
  output logic              sck_tick,
  output logic [3:0]        pad_oe,
  inout  wire               miso_pad,
  inout  wire               mosi_pad,
  inout  wire               sck_pad,
  inout  wire               ss_pad
);

  localparam int CNT_W = (1 << RATE_W) - 1;

  ctl_t              ctl_q;
  logic [NPIN-1:0]   dir_bits;
  logic [RATE_W-1:0] rate_code;
  logic [1:0]        gpio_out;
  logic              rate_wr;
  logic              presc_clr;
  logic [CNT_W-1:0]  presc_cnt;
  logic [NPIN-1:0]   pad_val;
  logic [NPIN-1:0]   pad_lvl;
  logic              ss_lvl;
  logic              ctl_master, ctl_bidi, ctl_ssoe;

  assign pad_lvl    = {ss_pad, sck_pad, mosi_pad, miso_pad};
  assign ss_lvl     = pad_lvl[PIN_SS];
  assign ctl_master = ctl_q.master;
  assign ctl_bidi   = ctl_q.bidi;
  assign ctl_ssoe   = ctl_q.ss_oe;
  assign presc_clr  = rate_wr || xfer_start;
  assign sck_rx     = pad_lvl[PIN_SCK];
  assign ss_rx      = ss_lvl;

  spi_pinctl_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .gpio_lvl ({mosi_pad, miso_pad}),
    .ctl      (ctl_q),
    .dir      (dir_bits),
    .rate     (rate_code),
    .gpio_out (gpio_out),
    .rate_wr  (rate_wr)
  );

  spi_pinctl_route u_route (
    .ctl      (ctl_q),
    .dir      (dir_bits),
    .ss_lvl   (ss_lvl),
    .tx_bit   (tx_bit),
    .sck_drv  (sck_drv),
    .ss_drv   (ss_drv),
    .gpio_out (gpio_out),
    .pad_lvl  (pad_lvl),
    .oe       (pad_oe),
    .val      (pad_val),
    .rx_bit   (rx_bit)
  );

  spi_pinctl_presc #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .rate  (rate_code),
    .clr   (presc_clr),
    .cnt   (presc_cnt),
    .tick  (sck_tick)
  );

  // pad tristate drivers
  assign miso_pad = pad_oe[PIN_MISO] ? pad_val[PIN_MISO] : 1'bz;
  assign mosi_pad = pad_oe[PIN_MOSI] ? pad_val[PIN_MOSI] : 1'bz;
  assign sck_pad  = pad_oe[PIN_SCK]  ? pad_val[PIN_SCK]  : 1'bz;
  assign ss_pad   = pad_oe[PIN_SS]   ? pad_val[PIN_SS]   : 1'bz;

endmodule

// File: rtl/spi_pinctl_chk.sv
module spi_pinctl_chk #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        pad_oe,
  input logic              ctl_master,
  input logic              ctl_ssoe,
  input logic [3:0]        dir_bits,
  input logic              ss_lvl,
  input logic [RATE_W-1:0] rate_code,
  input logic              presc_clr,
  input logic [CNT_W-1:0]  presc_cnt,
  input logic              sck_tick,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);

  // R7
  slave_miso_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_master && pad_oe[0]) |-> (dir_bits[0] && !ss_lvl));

  // R8
  master_mosi_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_master |-> (pad_oe[1] == dir_bits[1]));

  // R9
  sck_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[2] |-> (ctl_master && dir_bits[2]));

  // R10
  ss_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[3] |-> (ctl_master && ctl_ssoe && dir_bits[3]));

  // R4
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> (presc_cnt == '0));

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_tick && rate_code != '0 && !presc_clr) |=> !sck_tick);

  // R2
  rate_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[DATA_W-1:RATE_W] == '0));

endmodule

bind spi_pinctl spi_pinctl_chk #(.DATA_W(DATA_W), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pad_oe     (pad_oe),
  .ctl_master (ctl_master),
  .ctl_ssoe   (ctl_ssoe),
  .dir_bits   (dir_bits),
  .ss_lvl     (ss_lvl),
  .rate_code  (rate_code),
  .presc_clr  (presc_clr),
  .presc_cnt  (presc_cnt),
  .sck_tick   (sck_tick),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/spi_pinctl_bench.sv
`timescale 1ns/1ps
module spi_pinctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       xfer_start = 1'b0;
  logic       tx_bit = 1'b0, sck_drv = 1'b0, ss_drv = 1'b0;
  logic       rx_bit, sck_rx, ss_rx, sck_tick;
  logic [3:0] pad_oe;
  logic [3:0] tb_oe = 4'd0;
  logic [3:0] tb_lv = 4'd0;
  wire        miso_pad, mosi_pad, sck_pad, ss_pad;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign miso_pad = tb_oe[0] ? tb_lv[0] : 1'bz;
  assign mosi_pad = tb_oe[1] ? tb_lv[1] : 1'bz;
  assign sck_pad  = tb_oe[2] ? tb_lv[2] : 1'bz;
  assign ss_pad   = tb_oe[3] ? tb_lv[3] : 1'bz;

  spi_pinctl u_spi_pinctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
    .tx_bit(tx_bit), .sck_drv(sck_drv), .ss_drv(ss_drv), .rx_bit(rx_bit),
    .sck_rx(sck_rx), .ss_rx(ss_rx), .sck_tick(sck_tick), .pad_oe(pad_oe),
    .miso_pad(miso_pad), .mosi_pad(mosi_pad), .sck_pad(sck_pad), .ss_pad(ss_pad)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, 32'(reg_rdata), 32'(exp));
    reg_addr = 2'd0;
  endtask

  // observe ticks for n cycles; caller is at the negedge that is cycle 0
  task automatic tick_scan(input string req, input int half, input int n);
    for (int j = 0; j < n; j++) begin
      if (j != 0) @(negedge clk);
      #1;
      check(req, 32'(sck_tick), 32'((j % half) == (half - 1)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 32'd0);
    check("R1 tick", 32'(sck_tick), 32'd1);
    rd_check("R1 ctl", 2'd0, 8'd0);
    rd_check("R1 dir", 2'd1, 8'd0);
    rd_check("R1 rate", 2'd2, 8'd0);

    // R2, R3, R4: every rate code, cleared by the rate write
    for (int k = 0; k < 8; k++) begin
      wr(2'd2, 8'hF8 | 8'(k));
      tick_scan("R3 R4 rate write", 1 << k, 3 * (1 << k) + 1);
      rd_check("R2 rate readback", 2'd2, 8'(k));
    end

    // R4 transfer start clears mid-count; R2 write while transfer starts
    wr(2'd2, 8'd3);
    repeat (5) @(negedge clk);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    tick_scan("R4 xfer_start", 8, 20);
    @(negedge clk);
    xfer_start = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'd2;
    @(negedge clk);
    xfer_start = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0;
    rd_check("R2 write during transfer", 2'd2, 8'd2);
    tick_scan("R4 after combined clear", 4, 9);

    // R5..R11 sweep of modes, directions, slave select and data patterns
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 16; d++) begin
        for (int s = 0; s < 2; s++) begin
          for (int p = 0; p < 4; p++) begin
            logic ms, bi, so;
            logic [3:0] eo, ev, bv, lv;
            logic [1:0] go;
            logic rx_exp;
            ms = m[0]; bi = m[1]; so = m[2];
            go = {p[0], ~p[0]};
            bv = {s[0], p[0], ~p[1], p[1]};
            tb_oe = 4'd0;
            wr(2'd0, 8'(m));
            wr(2'd1, 8'(d));
            wr(2'd3, {6'd0, go});
            tx_bit = p[0]; sck_drv = ~p[1]; ss_drv = p[0] ^ p[1];
            eo = 4'd0; ev = 4'd0;
            case ({ms, bi})
              2'b10: begin eo[1] = d[1]; ev[1] = tx_bit; end
              2'b00: begin eo[0] = d[0] & ~s[0]; ev[0] = tx_bit; end
              2'b11: begin eo[0] = d[0]; ev[0] = go[0]; eo[1] = d[1]; ev[1] = tx_bit; end
              default: begin eo[0] = d[0] & ~s[0]; ev[0] = tx_bit; eo[1] = d[1]; ev[1] = go[1]; end
            endcase
            eo[2] = ms & d[2];        ev[2] = sck_drv;
            eo[3] = ms & so & d[3];   ev[3] = ss_drv;
            for (int i = 0; i < 4; i++) lv[i] = eo[i] ? ev[i] : bv[i];
            rx_exp = (ms == bi) ? lv[1] : lv[0];
            tb_lv = bv;
            tb_oe = ~eo;
            #1;
            check(bi ? "R6 R7 miso oe" : "R7 miso oe", 32'(pad_oe[0]), 32'(eo[0]));
            check(bi ? "R6 R8 mosi oe" : "R8 mosi oe", 32'(pad_oe[1]), 32'(eo[1]));
            check("R9 sck oe", 32'(pad_oe[2]), 32'(eo[2]));
            check("R10 ss oe", 32'(pad_oe[3]), 32'(eo[3]));
            check(bi ? "R6 data levels" : "R5 data levels",
                  32'({mosi_pad, miso_pad}), 32'(lv[1:0]));
            check("R9 sck level", 32'(sck_rx), 32'(lv[2]));
            check("R10 ss level", 32'(ss_rx), 32'(lv[3]));
            check("R11 rx source", 32'(rx_bit), 32'(rx_exp));
            rd_check("R6 gpio readback", 2'd3, {6'd0, lv[1], lv[0]});
          end
        end
      end
    end
    tb_oe = 4'd0;
    report();
  end

endmodule